// File: doc/BRIEF.md
# Event Counter Unit with Request ID Filtering

This block is a performance-monitoring unit: eight 64-bit event counters reached through a 32-bit register interface. Each counter is steered by an 8-bit event code to one of three sources: received requests, transmitted requests, or clock cycles. Codes that name none of these make the counter count nothing. A counter advances only while the global run bit and its own enable bit are both set. Software can preload any counter, one 32-bit half at a time, at any moment.

Request events can be narrowed by two ID filters, one on the source ID and one on the target ID. Each filter holds an 11-bit ID, an enable and an 11-bit don't-care mask. A request counts only if every enabled filter matches it. A separate qualifier can additionally require the request's trace-tag bit to be set.

When a counter wraps from all ones to zero it sets a sticky status bit. Software clears that bit by writing a one to it. The interrupt output is raised while any status bit is set whose mask bit is clear. The register interface is a single-cycle strobe: a write takes effect at the clock edge where `bus_valid` and `bus_write` are both high, and read data is a combinational function of `bus_addr`.

Top module: `perfmon_unit`

## Requirements
- R1: After reset all counters, the run bit, the counter enables, the trace-tag qualifier, both filters and all status bits are zero. The mask register reads 0xFF, `irq` is low, and the read-only word at 0x1CF0 returns the VERSION parameter (default 0x00020001).
- R2: Counter n is read and written as two 32-bit halves: the low half at 0x1D00+8n and the high half at 0x1D04+8n. A write loads that half and leaves the other half unchanged.
- R3: Bit 0 of the word at 0x1C00 is the global run bit. While it is clear no counter changes except through software writes. Only bit 0 is stored there.
- R4: Bit n of the word at 0x1C04 enables counter n. A disabled counter never advances. Only the low 8 bits are stored.
- R5: Counters 0-3 take their event codes from the word at 0x1C80, and counters 4-7 from the word at 0x1C84. Counter n uses byte n%4. Code 0x40 counts received requests, 0x5C counts transmitted requests, 0x78 counts every clock cycle, and any other code counts nothing.
- R6: When an increment wraps a counter from all ones to zero, status bit n is set at that same clock edge. The status word reads at 0x1C78 (bits 7:0).
- R7: Writing a one to bit n of the word at 0x1C7C clears status bit n. Zero bits leave status bits unchanged. A clear that coincides with a new wrap of the same counter leaves the bit set. Writes to 0x1C78 have no effect, and 0x1C7C reads as zero.
- R8: `irq` is high exactly when some status bit n is set while mask bit n (word 0x1C70, 1 = masked) is clear.
- R9: The target filter (0x1C14) and the source filter (0x1C18) each hold the ID in bits 10:0, the enable in bit 11 and the mask in bits 22:12 (23 bits stored). An enabled filter matches when the ID agrees on every bit whose mask bit is 0. A request event counts only if all enabled filters match. Cycle counting is never filtered.
- R10: Bit 4 of the word at 0x1C08 is the trace-tag qualifier, and only that bit is stored. While it is set, a request counts only if its tag input is high.
- R11: If a software write to a counter half and an increment of that counter fall on the same edge, the written value is kept and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_valid | input | 1 | Received-request strobe, one per cycle |
| rx_src_id | input | 11 | Source ID of the received request |
| rx_tgt_id | input | 11 | Target ID of the received request |
| rx_tag | input | 1 | Trace-tag bit of the received request |
| tx_valid | input | 1 | Transmitted-request strobe |
| tx_src_id | input | 11 | Source ID of the transmitted request |
| tx_tgt_id | input | 11 | Target ID of the transmitted request |
| tx_tag | input | 1 | Trace-tag bit of the transmitted request |
| irq | output | 1 | Interrupt: some unmasked status bit set |

## Verification
Counting is driven with several distinct patterns. Separate and simultaneous rx/tx strobes against six differently coded counters show that each code picks its own source and that an unknown code or a cleared enable counts nothing. Back-to-back run-bit toggles produce an exact single-cycle count, which shows that the run bit gates on the edge after it is written. A sweep of filter IDs that differ only in masked bits, and of IDs that differ in unmasked bits, separates the don't-care behaviour from the exact-match behaviour; the same sweep shows the tag qualifier acting alone. Preloads just below wrap, clears landing on the wrap edge, and writes landing on an increment edge settle the precedence rules.

// File: rtl/perfmon_pkg.sv
`timescale 1ns/1ps
package perfmon_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int ID_W   = 11;
    localparam int CODE_W = 8;
    localparam int LANES  = DATA_W / CODE_W;
    localparam int FILT_W = 2 * ID_W + 1;
    localparam int TT_BIT = 4;

    localparam logic [ADDR_W-1:0] A_RUN      = 16'h1C00;
    localparam logic [ADDR_W-1:0] A_CNT_EN   = 16'h1C04;
    localparam logic [ADDR_W-1:0] A_TAG_QUAL = 16'h1C08;
    localparam logic [ADDR_W-1:0] A_TGT_FILT = 16'h1C14;
    localparam logic [ADDR_W-1:0] A_SRC_FILT = 16'h1C18;
    localparam logic [ADDR_W-1:0] A_IMASK    = 16'h1C70;
    localparam logic [ADDR_W-1:0] A_ISTAT    = 16'h1C78;
    localparam logic [ADDR_W-1:0] A_ICLR     = 16'h1C7C;
    localparam logic [ADDR_W-1:0] A_EVSEL0   = 16'h1C80;
    localparam logic [ADDR_W-1:0] A_VERSION  = 16'h1CF0;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 16'h1D00;

    typedef enum logic [CODE_W-1:0] {
        EV_RX_REQ = 8'h40,
        EV_TX_REQ = 8'h5C,
        EV_CYCLE  = 8'h78
    } ev_code_e;

    // packed MSB first: mask [22:12], enable [11], id [10:0]
    typedef struct packed {
        logic [ID_W-1:0] mask;
        logic            en;
        logic [ID_W-1:0] id;
    } id_filt_t;

    typedef struct packed {
        logic            valid;
        logic            tag;
        logic [ID_W-1:0] src;
        logic [ID_W-1:0] tgt;
    } req_t;

    function automatic logic id_match(input id_filt_t f, input logic [ID_W-1:0] id);
        return !f.en || (((f.id ^ id) & ~f.mask) == '0);
    endfunction

endpackage

// File: rtl/perfmon_filter.sv
`timescale 1ns/1ps
module perfmon_filter
    import perfmon_pkg::*;
(
    input  req_t     req,
    input  id_filt_t src_filt,
    input  id_filt_t tgt_filt,
    input  logic     tag_qual,
    output logic     hit
);
    // R9 ID match on unmasked bits, R10 tag qualification
    assign hit = req.valid
              && (!tag_qual || req.tag)
              && id_match(src_filt, req.src)
              && id_match(tgt_filt, req.tgt);
endmodule

// File: rtl/perfmon_counter.sv
`timescale 1ns/1ps
module perfmon_counter
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    localparam int HALF = CNT_W / 2;

    // a software write beats a same-edge increment (R11)
    assign ovf = inc && !wr_lo && !wr_hi && (&count);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_lo) begin
            count[HALF-1:0] <= wdata;
        end else if (wr_hi) begin
            count[CNT_W-1:HALF] <= wdata;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (count[HALF-1:0] == $past(wdata)));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr_lo && !wr_hi) |=> $stable(count));

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (count == '0));
endmodule

// File: rtl/perfmon_regs.sv
`timescale 1ns/1ps
module perfmon_regs
    import perfmon_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter logic [31:0] VERSION = 32'h0002_0001
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_valid,
    input  logic                             bus_write,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_val,
    input  logic [NUM_CNT-1:0]               ovf,
    output logic                             run_en,
    output logic [NUM_CNT-1:0]               cnt_en,
    output logic                             tag_qual,
    output id_filt_t                         src_filt,
    output id_filt_t                         tgt_filt,
    output logic [NUM_CNT-1:0][CODE_W-1:0]   ev_code,
    output logic [NUM_CNT-1:0]               cnt_wr_lo,
    output logic [NUM_CNT-1:0]               cnt_wr_hi,
    output logic [NUM_CNT-1:0]               int_mask,
    output logic [NUM_CNT-1:0]               int_status
);
    localparam int NUM_SEL = NUM_CNT / LANES;
    localparam int IDX_W   = $clog2(NUM_CNT);
    localparam int WIN     = NUM_CNT * 8;
    localparam int HALF    = CNT_W / 2;

    logic                wr;
    logic [ADDR_W-1:0]   cnt_off;
    logic                in_win;
    logic [IDX_W-1:0]    cnt_idx;
    logic                hi_word;
    logic [NUM_CNT-1:0]  clr_vec;
    logic [DATA_W-1:0]   evsel_q [NUM_SEL];

    assign wr      = bus_valid && bus_write;
    assign cnt_off = bus_addr - A_CNT_BASE;
    assign in_win  = (cnt_off < ADDR_W'(WIN)) && (cnt_off[1:0] == 2'b00);
    assign cnt_idx = cnt_off[IDX_W+2:3];
    assign hi_word = cnt_off[2];
    assign clr_vec = (wr && bus_addr == A_ICLR) ? bus_wdata[NUM_CNT-1:0] : '0;

    // control and configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            run_en   <= 1'b0;
            cnt_en   <= '0;
            tag_qual <= 1'b0;
            src_filt <= '0;
            tgt_filt <= '0;
            int_mask <= '1;
            for (int k = 0; k < NUM_SEL; k++) evsel_q[k] <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_RUN:      run_en   <= bus_wdata[0];
                A_CNT_EN:   cnt_en   <= bus_wdata[NUM_CNT-1:0];
                A_TAG_QUAL: tag_qual <= bus_wdata[TT_BIT];
                A_TGT_FILT: tgt_filt <= id_filt_t'(bus_wdata[FILT_W-1:0]);
                A_SRC_FILT: src_filt <= id_filt_t'(bus_wdata[FILT_W-1:0]);
                A_IMASK:    int_mask <= bus_wdata[NUM_CNT-1:0];
                default: ;
            endcase
            for (int k = 0; k < NUM_SEL; k++) begin
                if (bus_addr == A_EVSEL0 + ADDR_W'(4 * k)) evsel_q[k] <= bus_wdata;
            end
        end
    end

    // sticky wrap status: a new wrap outranks a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) int_status <= '0;
        else     int_status <= (int_status & ~clr_vec) | ovf;
    end

    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) begin
            ev_code[n]   = evsel_q[n / LANES][CODE_W * (n % LANES) +: CODE_W];
            cnt_wr_lo[n] = wr && in_win && (cnt_idx == IDX_W'(n)) && !hi_word;
            cnt_wr_hi[n] = wr && in_win && (cnt_idx == IDX_W'(n)) && hi_word;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            bus_rdata = hi_word ? cnt_val[cnt_idx][CNT_W-1:HALF]
                                : cnt_val[cnt_idx][HALF-1:0];
        end else begin
            case (bus_addr)
                A_RUN:      bus_rdata = DATA_W'(run_en);
                A_CNT_EN:   bus_rdata = DATA_W'(cnt_en);
                A_TAG_QUAL: bus_rdata = DATA_W'(tag_qual) << TT_BIT;
                A_TGT_FILT: bus_rdata = DATA_W'(tgt_filt);
                A_SRC_FILT: bus_rdata = DATA_W'(src_filt);
                A_IMASK:    bus_rdata = DATA_W'(int_mask);
                A_ISTAT:    bus_rdata = DATA_W'(int_status);
                A_VERSION:  bus_rdata = VERSION;
                default: begin
                    for (int k = 0; k < NUM_SEL; k++) begin
                        if (bus_addr == A_EVSEL0 + ADDR_W'(4 * k)) bus_rdata = evsel_q[k];
                    end
                end
            endcase
        end
    end

    a_r6_status_sets: assert property (@(posedge clk) disable iff (rst)
        (|ovf) |=> ((int_status & $past(ovf)) == $past(ovf)));

    a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec != '0) && (ovf == '0)) |=> ((int_status & $past(clr_vec)) == '0));

    a_r1_mask_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int_mask == '1 && int_status == '0 && !run_en));
endmodule

// File: rtl/perfmon_unit.sv
`timescale 1ns/1ps
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter logic [31:0] VERSION = 32'h0002_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_src_id,
    input  logic [ID_W-1:0]   rx_tgt_id,
    input  logic              rx_tag,
    input  logic              tx_valid,
    input  logic [ID_W-1:0]   tx_src_id,
    input  logic [ID_W-1:0]   tx_tgt_id,
    input  logic              tx_tag,
    output logic              irq
);
    logic                           run_en;
    logic                           tag_qual;
    logic [NUM_CNT-1:0]             cnt_en;
    id_filt_t                       src_filt;
    id_filt_t                       tgt_filt;
    logic [NUM_CNT-1:0][CODE_W-1:0] ev_code;
    logic [NUM_CNT-1:0]             cnt_wr_lo;
    logic [NUM_CNT-1:0]             cnt_wr_hi;
    logic [NUM_CNT-1:0]             int_mask;
    logic [NUM_CNT-1:0]             int_status;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val;
    logic [NUM_CNT-1:0]             ovf;
    req_t [1:0]                     streams;
    logic [1:0]                     req_hit;

    assign streams[0] = '{valid: rx_valid, tag: rx_tag, src: rx_src_id, tgt: rx_tgt_id};
    assign streams[1] = '{valid: tx_valid, tag: tx_tag, src: tx_src_id, tgt: tx_tgt_id};

    perfmon_regs #(.NUM_CNT(NUM_CNT), .VERSION(VERSION)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_val    (cnt_val),
        .ovf        (ovf),
        .run_en     (run_en),
        .cnt_en     (cnt_en),
        .tag_qual   (tag_qual),
        .src_filt   (src_filt),
        .tgt_filt   (tgt_filt),
        .ev_code    (ev_code),
        .cnt_wr_lo  (cnt_wr_lo),
        .cnt_wr_hi  (cnt_wr_hi),
        .int_mask   (int_mask),
        .int_status (int_status)
    );

    for (genvar s = 0; s < 2; s++) begin : g_stream
        perfmon_filter u_filt (
            .req      (streams[s]),
            .src_filt (src_filt),
            .tgt_filt (tgt_filt),
            .tag_qual (tag_qual),
            .hit      (req_hit[s])
        );
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic ev_hit;
        logic inc;

        // R5 event steering by code
        always_comb begin
            case (ev_code[n])
                EV_RX_REQ: ev_hit = req_hit[0];
                EV_TX_REQ: ev_hit = req_hit[1];
                EV_CYCLE:  ev_hit = 1'b1;
                default:   ev_hit = 1'b0;
            endcase
        end

        assign inc = run_en && cnt_en[n] && ev_hit;

        perfmon_counter u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc),
            .wr_lo (cnt_wr_lo[n]),
            .wr_hi (cnt_wr_hi[n]),
            .wdata (bus_wdata),
            .count (cnt_val[n]),
            .ovf   (ovf[n])
        );
    end

    assign irq = |(int_status & ~int_mask);

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (int_mask == '1) |-> !irq);

    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (rst)
        (!run_en && cnt_wr_lo == '0 && cnt_wr_hi == '0) |=> $stable(cnt_val));
endmodule

// File: tb/perfmon_unit_tb.sv
`timescale 1ns/1ps
module perfmon_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_tag = 1'b0, tx_valid = 1'b0, tx_tag = 1'b0;
    logic [10:0] rx_src_id = '0, rx_tgt_id = '0, tx_src_id = '0, tx_tgt_id = '0;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    perfmon_unit u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_src_id(rx_src_id), .rx_tgt_id(rx_tgt_id), .rx_tag(rx_tag),
        .tx_valid(tx_valid), .tx_src_id(tx_src_id), .tx_tgt_id(tx_tgt_id), .tx_tag(tx_tag),
        .irq(irq)
    );

    localparam logic [15:0] RUN = 16'h1C00, CEN = 16'h1C04, TQ = 16'h1C08, TGT = 16'h1C14,
                            SRC = 16'h1C18, MSK = 16'h1C70, STA = 16'h1C78, CLR = 16'h1C7C,
                            ES0 = 16'h1C80, ES1 = 16'h1C84, VER = 16'h1CF0;

    function automatic logic [15:0] lo(input int n); return 16'h1D00 + 16'(8 * n); endfunction
    function automatic logic [15:0] hi(input int n); return 16'h1D04 + 16'(8 * n); endfunction

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    // register table: R4 enable width, R5 select words, R9 filter width,
    // R7 read-only status and zero-reading clear word, R10 qualifier bit,
    // R3 run bit, R2 counter half, R1 version word
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h1C04, 32'hFFFF_FFA5, 32'h0,          8'd4},
        '{1'b0, 16'h1C04, 32'h0,         32'h0000_00A5,  8'd4},
        '{1'b1, 16'h1C80, 32'h7840_5C11, 32'h0,          8'd5},
        '{1'b0, 16'h1C80, 32'h0,         32'h7840_5C11,  8'd5},
        '{1'b1, 16'h1C84, 32'h0000_5C40, 32'h0,          8'd5},
        '{1'b0, 16'h1C84, 32'h0,         32'h0000_5C40,  8'd5},
        '{1'b1, 16'h1C14, 32'hFFFF_FFFF, 32'h0,          8'd9},
        '{1'b0, 16'h1C14, 32'h0,         32'h007F_FFFF,  8'd9},
        '{1'b1, 16'h1C78, 32'h0000_00FF, 32'h0,          8'd7},
        '{1'b0, 16'h1C78, 32'h0,         32'h0,          8'd7},
        '{1'b0, 16'h1C7C, 32'h0,         32'h0,          8'd7},
        '{1'b1, 16'h1C08, 32'hFFFF_FFFF, 32'h0,          8'd10},
        '{1'b0, 16'h1C08, 32'h0,         32'h0000_0010,  8'd10},
        '{1'b1, 16'h1C00, 32'hFFFF_FFFE, 32'h0,          8'd3},
        '{1'b0, 16'h1C00, 32'h0,         32'h0,          8'd3},
        '{1'b1, 16'h1D0C, 32'h1234_5678, 32'h0,          8'd2},
        '{1'b0, 16'h1D0C, 32'h0,         32'h1234_5678,  8'd2},
        '{1'b0, 16'h1CF0, 32'h0,         32'h0002_0001,  8'd1}
    };

    task automatic idle_inputs();
        rx_valid = 1'b0; tx_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic r, input logic t, input logic [10:0] s,
                         input logic [10:0] g, input logic tag);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rx_valid = r; tx_valid = t;
        rx_src_id = s; tx_src_id = s; rx_tgt_id = g; tx_tgt_id = g;
        rx_tag = tag; tx_tag = tag;
        @(posedge clk);
    endtask

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic chk_rd(input string what, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(what, v, exp);
    endtask

    task automatic chk_irq(input string what, input logic exp);
        @(negedge clk);
        idle_inputs();
        bus_valid = 1'b0;
        #1 check(what, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        bus_valid = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        chk_rd("R1 counter0 low after reset", lo(0), 32'h0);
        chk_rd("R1 counter7 high after reset", hi(7), 32'h0);
        chk_rd("R1 mask after reset", MSK, 32'h0000_00FF);
        chk_rd("R1 status after reset", STA, 32'h0);
        chk_rd("R1 enables after reset", CEN, 32'h0);
        chk_irq("R1 irq after reset", 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].addr, VEC[i].data);
            end else begin
                rd(VEC[i].addr, v);
                check($sformatf("R%0d table entry %0d", VEC[i].req, i), v, VEC[i].exp);
            end
        end

        // R3 exact gating: run set on one edge, cleared on the next -> one cycle counted
        do_reset();
        wr(ES0, 32'h0000_0078);
        wr(CEN, 32'h1);
        wr(RUN, 32'h1);
        wr(RUN, 32'h0);
        chk_rd("R3 single counted cycle", lo(0), 32'h1);
        chk_rd("R3 no counting while run clear", lo(0), 32'h1);

        // R4 R5 event steering
        do_reset();
        wr(ES0, 32'h1178_5C40);
        wr(ES1, 32'h0000_5C40);
        wr(CEN, 32'h0000_0027);
        wr(RUN, 32'h1);
        pulse(1'b1, 1'b0, 11'h0, 11'h0, 1'b0);
        pulse(1'b1, 1'b0, 11'h0, 11'h0, 1'b0);
        pulse(1'b1, 1'b1, 11'h0, 11'h0, 1'b0);
        pulse(1'b0, 1'b1, 11'h0, 11'h0, 1'b0);
        wr(RUN, 32'h0);
        chk_rd("R5 rx code 0x40 counter0", lo(0), 32'd3);
        chk_rd("R5 tx code 0x5C counter1", lo(1), 32'd2);
        rd(lo(2), v);
        check("R5 cycle code 0x78 counter2 nonzero", {31'b0, v != 0}, 32'h1);
        chk_rd("R5 unknown code counter3", lo(3), 32'h0);
        chk_rd("R4 disabled counter4", lo(4), 32'h0);
        chk_rd("R5 upper select word counter5", lo(5), 32'd2);
        chk_rd("R5 counter0 high half", hi(0), 32'h0);

        // R9 ID filters
        do_reset();
        wr(ES0, 32'h0000_7840);
        wr(CEN, 32'h3);
        wr(TGT, 32'h0000_F955);              // id 0x155, enable, mask 0x00F
        wr(RUN, 32'h1);
        pulse(1'b1, 1'b0, 11'h000, 11'h15A, 1'b0);   // masked bits differ: counts
        pulse(1'b1, 1'b0, 11'h000, 11'h055, 1'b0);   // bit 8 differs: dropped
        wr(SRC, 32'h0000_0FFF);              // id 0x7FF, enable, mask 0
        pulse(1'b1, 1'b0, 11'h7FF, 11'h150, 1'b0);   // both match: counts
        pulse(1'b1, 1'b0, 11'h7FE, 11'h155, 1'b0);   // source mismatch: dropped
        wr(SRC, 32'h0);
        pulse(1'b1, 1'b0, 11'h000, 11'h155, 1'b0);   // source filter off: counts
        wr(RUN, 32'h0);
        chk_rd("R9 filtered request count", lo(0), 32'd3);
        rd(lo(1), v);
        check("R9 cycle counting unfiltered", {31'b0, v != 0}, 32'h1);

        // R10 trace-tag qualifier
        do_reset();
        wr(ES0, 32'h0000_005C);
        wr(CEN, 32'h1);
        wr(TQ, 32'h10);
        wr(RUN, 32'h1);
        pulse(1'b0, 1'b1, 11'h0, 11'h0, 1'b0);
        pulse(1'b0, 1'b1, 11'h0, 11'h0, 1'b1);
        wr(RUN, 32'h0);
        chk_rd("R10 only tagged request counted", lo(0), 32'd1);

        // R2 R6 R8 R7 wrap, status, interrupt, clear
        do_reset();
        wr(ES0, 32'h7800_0000);
        wr(CEN, 32'h08);
        wr(MSK, 32'hF7);
        wr(lo(3), 32'hFFFF_FFFE);
        wr(hi(3), 32'hFFFF_FFFF);
        chk_rd("R2 preloaded low half", lo(3), 32'hFFFF_FFFE);
        wr(RUN, 32'h1);
        wr(RUN, 32'h0);
        chk_rd("R2 at all ones high", hi(3), 32'hFFFF_FFFF);
        chk_rd("R6 no status before wrap", STA, 32'h0);
        chk_irq("R8 irq low before wrap", 1'b0);
        wr(RUN, 32'h1);
        wr(RUN, 32'h0);
        chk_rd("R6 wrapped low", lo(3), 32'h0);
        chk_rd("R6 wrapped high", hi(3), 32'h0);
        chk_rd("R6 status after wrap", STA, 32'h08);
        chk_irq("R8 irq raised unmasked", 1'b1);
        wr(MSK, 32'hFF);
        chk_irq("R8 irq low when masked", 1'b0);
        wr(STA, 32'h0);
        chk_rd("R7 status word not writable", STA, 32'h08);
        wr(CLR, 32'h01);
        chk_rd("R7 clear of other bit", STA, 32'h08);
        wr(CLR, 32'h08);
        chk_rd("R7 write-one clear", STA, 32'h0);

        // R7 clear on the same edge as a new wrap
        wr(lo(3), 32'hFFFF_FFFF);
        wr(hi(3), 32'hFFFF_FFFF);
        wr(RUN, 32'h1);
        wr(RUN, 32'h0);
        chk_rd("R7 status set again", STA, 32'h08);
        wr(lo(3), 32'hFFFF_FFFF);
        wr(hi(3), 32'hFFFF_FFFF);
        wr(RUN, 32'h1);
        wr(CLR, 32'h08);                     // wrap and clear on this edge
        wr(RUN, 32'h0);
        chk_rd("R7 wrap outranks clear", STA, 32'h08);

        // R11 write beats same-edge increment
        do_reset();
        wr(ES0, 32'h0000_0078);
        wr(CEN, 32'h1);
        wr(RUN, 32'h1);
        wr(lo(0), 32'h0000_0100);
        wr(RUN, 32'h0);
        chk_rd("R11 write wins over increment", lo(0), 32'h0000_0101);

        finish_run();
    end
endmodule